// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in the master-clock domain of an audio DAC. It measures how many master clocks fit into one period of the sample-rate word clock and picks the oversampling ratio that the period matches. It needs no configuration input. There are six supported ratios: 128, 192, 256, 384, 512 and 768 master clocks per sample. The result goes to the clock-generation and filter logic as a 3-bit code, a locked flag and a fault flag. The fault flag shuts the conversion path down and mutes the output.

The word clock arrives without a fixed phase relation to the master clock. It is brought in through a short synchronizer chain. The block then counts master clocks between successive synchronized rising edges. A measured period is accepted when it lies within a symmetric tolerance of a nominal ratio, so small phase jitter does not disturb a settled result. Lock needs agreement between two consecutive periods. A missing word clock is caught by a timeout.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is high and after it is released, before any word-clock edge, the outputs are ratio_code = 0, locked = 0 and fault = 0.
- R2: The ratio code is ascending: 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512, 5 = 768 master clocks per word-clock period. A locked result carries the code of the ratio it locked to.
- R3: A period is the number of master clocks between two successive rising word-clock edges. It matches a ratio when it lies within nominal-8 to nominal+8 inclusive.
- R4: A period that matches no ratio sets fault = 1 and locked = 0.
- R5: locked rises only when two consecutive periods match the same ratio. Reaching lock clears fault. locked and fault are never both 1.
- R6: When a matching period names a different ratio from the previous matching period, locked = 0 and fault = 1. One further period of the new ratio then locks to it.
- R7: If 1024 master clocks pass without a rising word-clock edge, fault = 1 and locked = 0. The next edge only restarts measurement and is not a period end.
- R8: The outputs reflect a completed period within five master clocks after the word-clock rise that ends it.
- R9: Periods that vary within the tolerance window of the locked ratio keep locked = 1 and fault = 0.
- R10: ratio_code changes only at the moment lock is reached. While unlocked or faulted it holds the last locked code.
- R11: After a fault, the first matching period leaves fault = 1. Fault clears only when lock is reached again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, asynchronous to mclk |
| ratio_code | output | 3 | Detected ratio code (R2 encoding) |
| locked | output | 1 | Ratio settled on two agreeing periods |
| fault | output | 1 | No valid ratio; shut down and mute |

## Verification
The bench drives periods exactly on each window edge (120, 136, 184, 200) and just outside (119, 137). An off-by-one window would either fault on a legal rate or accept an illegal one. It steps through all six ratios in sequence. An error there would show as a missed fault on a ratio change or a wrong code ordering. It holds the word clock idle twice: once short of the timeout, where the result must stay locked, and once past it, where a wrong counter would leave a dead clock looking locked. It also checks the two-period recovery after a timeout, where a design that treats the first edge as a period end would report a huge bogus period.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;

    // Ascending ratio encoding
    typedef enum logic [CODE_W-1:0] {
        FS128 = 3'd0,
        FS192 = 3'd1,
        FS256 = 3'd2,
        FS384 = 3'd3,
        FS512 = 3'd4,
        FS768 = 3'd5
    } ratio_e;

    // Result of classifying one measured period
    typedef struct packed {
        logic   hit;
        ratio_e code;
    } class_t;

    // Nominal master clocks per sample for ratio index idx:
    // even indices are 2*64 << (idx/2), odd ones 3*64 << (idx/2)
    function automatic int nominal_ratio(input int idx);
        int mant;
        mant = ((idx % 2) != 0) ? 3 : 2;
        return (mant << (idx / 2)) << 6;
    endfunction

endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mrd_period_meter.sv
module mrd_period_meter #(
    parameter int TIMEOUT_CYC = 1024,
    parameter int CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl,         // synchronized word clock
    output logic             meas_valid,  // one-cycle pulse: meas_count holds a full period
    output logic [CNT_W-1:0] meas_count,
    output logic             tout         // one-cycle pulse: no edge for TIMEOUT_CYC clocks
);

    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic             lvl_d;
    logic             rise;
    logic [CNT_W-1:0] run_cnt;
    logic             have_ref;   // an edge has been seen since reset or timeout

    assign rise = lvl & ~lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d      <= 1'b0;
            run_cnt    <= '0;
            have_ref   <= 1'b0;
            meas_valid <= 1'b0;
            meas_count <= '0;
            tout       <= 1'b0;
        end else begin
            lvl_d      <= lvl;
            meas_valid <= 1'b0;
            tout       <= 1'b0;
            if (rise) begin
                meas_valid <= have_ref;
                meas_count <= run_cnt + 1'b1;
                run_cnt    <= '0;
                have_ref   <= 1'b1;
            end else if (run_cnt != CNT_SAT) begin
                run_cnt <= run_cnt + 1'b1;
                if (run_cnt == CNT_LAST) begin
                    tout     <= 1'b1;
                    have_ref <= 1'b0;
                end
            end
        end
    end

    // R3: a measurement is only produced by a rising edge one cycle earlier
    p_meas_from_edge_r3: assert property (@(posedge clk) disable iff (rst)
        meas_valid |-> $past(rise));

    // R7: a timeout pulse never coincides with a measurement
    p_tout_no_meas_r7: assert property (@(posedge clk) disable iff (rst)
        tout |-> !meas_valid);

endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
    import mrd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 8
) (
    input  logic [CNT_W-1:0] count,
    output class_t           res
);

    logic [NUM_RATIOS-1:0] in_win;

    generate
        for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_win
            localparam int NOM = nominal_ratio(k);
            assign in_win[k] = (int'(count) >= NOM - TOL) && (int'(count) <= NOM + TOL);
        end
    endgenerate

    always_comb begin
        res.hit  = |in_win;
        res.code = FS128;
        for (int k = NUM_RATIOS - 1; k >= 0; k--) begin
            if (in_win[k]) res.code = ratio_e'(CODE_W'(k));
        end
    end

endmodule

// File: rtl/mrd_lock_tracker.sv
module mrd_lock_tracker
    import mrd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   meas_valid,
    input  class_t cls,
    input  logic   tout,
    output ratio_e ratio_code,
    output logic   locked,
    output logic   fault
);

    logic   have_prev;
    ratio_e prev_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_code <= FS128;
            locked     <= 1'b0;
            fault      <= 1'b0;
            have_prev  <= 1'b0;
            prev_code  <= FS128;
        end else if (tout) begin
            locked    <= 1'b0;
            fault     <= 1'b1;
            have_prev <= 1'b0;
        end else if (meas_valid) begin
            if (!cls.hit) begin
                locked    <= 1'b0;
                fault     <= 1'b1;
                have_prev <= 1'b0;
            end else begin
                have_prev <= 1'b1;
                prev_code <= cls.code;
                if (have_prev && cls.code == prev_code) begin
                    locked     <= 1'b1;
                    fault      <= 1'b0;
                    ratio_code <= cls.code;
                end else if (have_prev) begin
                    locked <= 1'b0;
                    fault  <= 1'b1;
                end
            end
        end
    end

    p_lock_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(locked && fault));

    p_lock_hit_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(meas_valid && cls.hit));

    p_miss_fault_r4: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && !cls.hit) |=> (fault && !locked));

    p_mismatch_r6: assert property (@(posedge clk) disable iff (rst)
        (meas_valid && cls.hit && have_prev && cls.code != prev_code) |=> (fault && !locked));

    p_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        tout |=> (fault && !locked));

    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio_code) |-> locked);

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 1024,
    parameter int TOL         = 8
) (
    input  logic              mclk,
    input  logic              rst,
    input  logic              wclk_in,
    output logic [CODE_W-1:0] ratio_code,
    output logic              locked,
    output logic              fault
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             wclk_s;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_count;
    logic             tout;
    class_t           cls;
    ratio_e           code_q;

    mrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (mclk),
        .rst (rst),
        .d   (wclk_in),
        .q   (wclk_s)
    );

    mrd_period_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_meter (
        .clk        (mclk),
        .rst        (rst),
        .lvl        (wclk_s),
        .meas_valid (meas_valid),
        .meas_count (meas_count),
        .tout       (tout)
    );

    mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .count (meas_count),
        .res   (cls)
    );

    mrd_lock_tracker u_track (
        .clk        (mclk),
        .rst        (rst),
        .meas_valid (meas_valid),
        .cls        (cls),
        .tout       (tout),
        .ratio_code (code_q),
        .locked     (locked),
        .fault      (fault)
    );

    assign ratio_code = code_q;

    // R3: a reported hit lies inside the tolerance window of its code
    p_hit_window_r3: assert property (@(posedge mclk) disable iff (rst)
        (meas_valid && cls.hit) |->
            ((int'(meas_count) >= nominal_ratio(int'(cls.code)) - TOL) &&
             (int'(meas_count) <= nominal_ratio(int'(cls.code)) + TOL)));

endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 1024;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wclk = 1'b0;
    logic [2:0] ratio_code;
    logic       locked;
    logic       fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    mclk_ratio_detect u_dut (
        .mclk       (clk),
        .rst        (rst),
        .wclk_in    (wclk),
        .ratio_code (ratio_code),
        .locked     (locked),
        .fault      (fault)
    );

    typedef struct {
        logic [2:0] code;
        logic       lock;
        logic       flt;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // independent reference of the requirements
    int         noms[6] = '{128, 192, 256, 384, 512, 768};
    logic [2:0] m_code  = 3'd0;
    logic       m_lock  = 1'b0;
    logic       m_fault = 1'b0;
    bit         m_ref   = 1'b0;
    bit         m_prev_ok = 1'b0;
    int         m_prev  = 0;
    int         cur_len = 0;

    task automatic compare(input exp_t e);
        n_chk++;
        if (ratio_code !== e.code || locked !== e.lock || fault !== e.flt) begin
            n_bad++;
            $display("FAIL %s: actual code=%0d locked=%0b fault=%0b, expected code=%0d locked=%0b fault=%0b",
                     e.req, ratio_code, locked, fault, e.code, e.lock, e.flt);
        end
    endtask

    task automatic push(input string req);
        exp_t e;
        e.code = m_code; e.lock = m_lock; e.flt = m_fault; e.req = req;
        q.push_back(e);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // model step at a word-clock rise; returns a label
    function automatic string model_rise(input int len);
        int c;
        c = -1;
        if (!m_ref) begin
            m_ref = 1'b1;
            return "R7 reference edge";
        end
        for (int k = 0; k < 6; k++)
            if (len >= noms[k] - 8 && len <= noms[k] + 8) c = k;
        if (c < 0) begin
            m_lock = 1'b0; m_fault = 1'b1; m_prev_ok = 1'b0;
            return "R4 out of window";
        end
        if (m_prev_ok && c == m_prev) begin
            m_lock = 1'b1; m_fault = 1'b0; m_code = 3'(c);
            m_prev = c;
            return "R2 R5 lock";
        end
        if (m_prev_ok) begin
            m_lock = 1'b0; m_fault = 1'b1; m_prev = c;
            return "R6 ratio change";
        end
        m_prev_ok = 1'b1; m_prev = c;
        return "R11 first match";
    endfunction

    // caller stands at a negedge; drives one word-clock period of n clocks
    task automatic rise(input int n, input string tag);
        string lbl;
        wclk = 1'b1;
        lbl = model_rise(cur_len);
        push({tag, " R8 ", lbl, " R10"});
        repeat (n/2) @(negedge clk);
        wclk = 1'b0;
        repeat (n - n/2) @(negedge clk);
        cur_len = n;
    endtask

    // word clock held low for k more clocks, checked after 'at' clocks
    task automatic idle(input int k, input int at, input string tag);
        repeat (at) @(negedge clk);
        if (m_ref && cur_len + at > TMO) begin
            m_lock = 1'b0; m_fault = 1'b1; m_prev_ok = 1'b0; m_ref = 1'b0;
        end
        push(tag);
        repeat (k - at) @(negedge clk);
        cur_len += k;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (q.size() > 0);
            repeat (5) @(negedge clk);
            compare(q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual run not finished, expected finish within %0d cycles", WATCHDOG);
        finish_run();
    end

    initial begin
        exp_t r;
        repeat (4) @(negedge clk);
        r.code = 3'd0; r.lock = 1'b0; r.flt = 1'b0; r.req = "R1 during reset";
        compare(r);
        rst = 1'b0;
        @(negedge clk);
        r.req = "R1 after reset";
        compare(r);

        // every ratio in ascending order: R2, R5, R6, R11
        for (int i = 0; i < 6; i++) begin
            rise(noms[i], "sweep");
            rise(noms[i], "sweep");
            rise(noms[i], "sweep");
        end

        // jitter inside the 256 window
        rise(248, "R9 jitter");
        rise(264, "R9 jitter");
        rise(250, "R9 jitter");
        rise(262, "R9 jitter");
        rise(256, "R9 jitter");

        // window edges around 128 and 192
        rise(136, "R3 edge");
        rise(120, "R3 edge");
        rise(136, "R3 edge");
        rise(137, "R3 edge");
        rise(119, "R3 edge");
        rise(200, "R3 edge");
        rise(184, "R3 edge");
        rise(192, "R3 edge");
        rise(384, "R3 edge");
        rise(384, "R6 R10");
        rise(384, "R5");

        // idle short of the timeout, then the long period is a miss
        idle(300, 150, "R7 no early timeout");
        rise(512, "R4 long period");
        rise(512, "R11");
        rise(512, "R5");
        rise(512, "R5");

        // idle beyond the timeout, then recovery takes two periods
        idle(900, 700, "R7 timeout fault R10");
        rise(256, "R7 restart");
        rise(256, "R11 recover");
        rise(256, "R5 relock");
        rise(256, "R2 final");

        wait (q.size() == 0);
        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule